// File: doc/BRIEF.md
# Clock-Sync Mode Control FSM

This block supervises the reference selection and lock state of a line-card clock-synchronisation loop. It watches a set of candidate reference inputs. Each input has a validity flag from an external frequency monitor and a priority value. The block also watches a phase-lock indication from the loop. From these it decides which input the loop should track and which operating mode the loop is in. Every second counter advances only on a one-cycle pulse from a 1 Hz tick input, so the timing is independent of the system clock rate.

Acquisition of a reference is time-boxed. While acquiring, the block waits for phase lock to hold over two consecutive ticks. If that does not happen within a programmable number of ticks, the input is disqualified and the block pulses a one-cycle alarm for it. It then moves on to the next best input. It falls back to free-run once no input has been usable for two ticks. In revertive mode, a better input that appears during acquisition pre-empts the current attempt. Software can load any state directly. Every state change or restart sets a sticky status bit that drives an interrupt request when enabled. All pins are plain control and status levels or pulses. There is no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `sync_mode_ctrl`

## Requirements
- R1: After reset the state code is 000 (free-run), sel_vld_o is 0, alarm_o is 0, and chg_sticky and irq are 0. The state codes are: 000 free-run, 001 holdover, 010 locked, 011 prelocked, 100 prelocked-2, 101 loss-of-lock.
- R2: An input is usable when its in_valid bit is 1 and it is not disqualified. In free-run, the first cycle with any usable input moves the state to prelocked (011) and selects the best usable input. A lower priority value wins, and on equal values the lower index wins.
- R3: In prelocked or prelocked-2, the state becomes locked (010) on the second consecutive tick at which phase_lock is sampled high. A tick with phase_lock low resets that count.
- R4: In prelocked or prelocked-2 with lock_timeout = T > 0, the T-th tick since entry (when R3 does not fire) expires the attempt. alarm_o pulses for one cycle with the bit of the selected input set. That input stays disqualified until its in_valid bit goes low. The state becomes prelocked on the best other usable input, or prelocked with sel_vld_o = 0 if there is none. T = 0 disables the timeout.
- R5: In prelocked or prelocked-2 with no usable selected input and no other usable input, sel_vld_o is 0, and the second tick in that condition returns the state to free-run.
- R6: When revert_en = 1 and, in prelocked, prelocked-2 or locked, a usable input with a strictly lower priority value than the selected one exists, the block restarts prelocked (011) on it. With revert_en = 0 such an input is ignored.
- R7: In locked, phase_lock low moves to loss-of-lock (101). In loss-of-lock, phase_lock high returns to locked. The second tick without lock moves to prelocked-2 (100) on the same input.
- R8: In locked or loss-of-lock, an unusable selected input moves to holdover (001) with sel_vld_o = 0. In holdover, any usable input moves to prelocked-2 on the best usable input.
- R9: force_we with force_code 000..101 loads that state. Free-run and holdover clear sel_vld_o. Codes 110 and 111 are ignored.
- R10: chg_sticky is set on every state change and every acquisition restart. chg_clr = 1 clears it unless a new event occurs in the same cycle. irq equals chg_sticky AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| in_valid | input | N_IN | Per-input validity from the frequency monitors |
| prio_i | input | N_IN*PW | Packed per-input priority values, input 0 in the low bits; lower is better |
| phase_lock | input | 1 | Phase-lock indication from the loop |
| revert_en | input | 1 | Enables revertive pre-emption by better inputs |
| lock_timeout | input | TO_W | Acquisition window in ticks, 0 = unlimited (typical 100) |
| force_we | input | 1 | Load force_code into the state register |
| force_code | input | 3 | State code to load |
| chg_clr | input | 1 | Write-one-to-clear of the sticky state-change bit |
| irq_en | input | 1 | Interrupt enable for the sticky bit |
| state_o | output | 3 | Current state code |
| sel_o | output | IW | Index of the selected input |
| sel_vld_o | output | 1 | sel_o names an input being tracked |
| alarm_o | output | N_IN | One-cycle lock-timeout alarm, one bit per input |
| chg_sticky | output | 1 | Sticky state-change status |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result is due one rising edge after the cycle whose inputs cause it: state_o, sel_o, sel_vld_o, alarm_o and chg_sticky. A change of irq_en reaches irq in the same cycle, because irq is only a gate on the sticky bit. The bench changes inputs at a falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Each tick, force write or clear therefore lasts one cycle. A multi-second window such as the timeout is walked tick by tick, with the expected state known at every step.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    ST_FREE = 3'd0,
    ST_HOLD = 3'd1,
    ST_LOCK = 3'd2,
    ST_PRE  = 3'd3,
    ST_PRE2 = 3'd4,
    ST_LOL  = 3'd5
  } smc_state_e;

  localparam logic [2:0] ST_LAST = 3'd5;
endpackage

// File: rtl/smc_pick.sv
// Chooses the best input in a mask: lowest priority value, ties to lowest index.
module smc_pick #(
  parameter int N  = 4,
  parameter int PW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    mask,
  input  logic [N*PW-1:0] prio,
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   win_prio
);
  always_comb begin
    any      = 1'b0;
    idx      = '0;
    win_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!any || (prio[i*PW +: PW] < win_prio))) begin
        any      = 1'b1;
        idx      = IW'(i);
        win_prio = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/smc_qual.sv
// Per-input disqualification after a lock timeout, plus the alarm strobe.
module smc_qual #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  in_valid,
  input  logic          expire,
  input  logic [IW-1:0] exp_idx,
  output logic [N-1:0]  usable,
  output logic [N-1:0]  alarm_o
);
  logic [N-1:0] disq;

  for (genvar i = 0; i < N; i++) begin : g_in
    logic hit;
    logic dq;
    logic al;
    assign hit = expire && (exp_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq <= 1'b0;
        al <= 1'b0;
      end else begin
        dq <= in_valid[i] & (dq | hit);
        al <= hit;
      end
    end
    assign disq[i]    = dq;
    assign alarm_o[i] = al;
  end

  assign usable = in_valid & ~disq;
endmodule

// File: rtl/smc_flag.sv
// Sticky state-change bit with write-one-to-clear and interrupt gate.
module smc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic en,
  output logic sticky,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= 1'b0;
    else        sticky <= evt | (sticky & ~clr);
  end
  assign irq = sticky & en;
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import smc_pkg::*;
#(
  parameter int N_IN        = 4,
  parameter int PW          = 3,
  parameter int TO_W        = 8,
  parameter int LOCK_SECS   = 2,
  parameter int SETTLE_SECS = 2,
  parameter int LOL_SECS    = 2,
  localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int LCW = $clog2(LOCK_SECS + 1),
  localparam int AXM = (SETTLE_SECS > LOL_SECS) ? SETTLE_SECS : LOL_SECS,
  localparam int ACW = $clog2(AXM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [N_IN-1:0]    in_valid,
  input  logic [N_IN*PW-1:0] prio_i,
  input  logic               phase_lock,
  input  logic               revert_en,
  input  logic [TO_W-1:0]    lock_timeout,
  input  logic               force_we,
  input  logic [2:0]         force_code,
  input  logic               chg_clr,
  input  logic               irq_en,
  output logic [2:0]         state_o,
  output logic [IW-1:0]      sel_o,
  output logic               sel_vld_o,
  output logic [N_IN-1:0]    alarm_o,
  output logic               chg_sticky,
  output logic               irq
);
  smc_state_e     st_q, st_d;
  logic [IW-1:0]  sel_q, sel_d;
  logic           selv_q, selv_d;
  logic [LCW-1:0] lk_q, lk_d;
  logic [TO_W-1:0] to_q, to_d;
  logic [ACW-1:0] ax_q, ax_d;
  logic           expire, restart, chg_evt;

  logic [N_IN-1:0] usable, sel_oh, pick_mask;
  logic            cand_any;
  logic [IW-1:0]   cand_idx;
  logic [PW-1:0]   cand_prio, sel_prio;
  logic            sel_ok, better, to_hit;

  smc_qual #(.N(N_IN)) u_qual (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .expire(expire), .exp_idx(sel_q),
    .usable(usable), .alarm_o(alarm_o)
  );

  // The tracked input is left out of the candidate search while it is held.
  assign sel_oh    = N_IN'(1) << sel_q;
  assign pick_mask = usable & ~(sel_oh & {N_IN{selv_q}});

  smc_pick #(.N(N_IN), .PW(PW)) u_pick (
    .mask(pick_mask), .prio(prio_i),
    .any(cand_any), .idx(cand_idx), .win_prio(cand_prio)
  );

  assign sel_prio = prio_i[sel_q*PW +: PW];
  assign sel_ok   = selv_q & usable[sel_q];
  assign better   = revert_en & sel_ok & cand_any & (cand_prio < sel_prio);
  assign to_hit   = (lock_timeout != '0) &&
                    (({1'b0, to_q} + 1'b1) >= {1'b0, lock_timeout});

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    selv_d  = selv_q;
    lk_d    = lk_q;
    to_d    = to_q;
    ax_d    = ax_q;
    expire  = 1'b0;
    restart = 1'b0;
    if (force_we && (force_code <= ST_LAST)) begin
      st_d = smc_state_e'(force_code);
      lk_d = '0;
      to_d = '0;
      ax_d = '0;
      if (force_code == ST_FREE || force_code == ST_HOLD) selv_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_FREE: begin
          if (cand_any) begin
            st_d   = ST_PRE;
            sel_d  = cand_idx;
            selv_d = 1'b1;
            lk_d   = '0;
            to_d   = '0;
            ax_d   = '0;
          end
        end
        ST_PRE, ST_PRE2: begin
          if (!sel_ok) begin
            lk_d = '0;
            to_d = '0;
            if (cand_any) begin
              st_d    = ST_PRE;
              sel_d   = cand_idx;
              selv_d  = 1'b1;
              ax_d    = '0;
              restart = 1'b1;
            end else begin
              selv_d = 1'b0;
              if (sec_tick) begin
                if (ax_q == ACW'(SETTLE_SECS - 1)) begin
                  st_d = ST_FREE;
                  ax_d = '0;
                end else begin
                  ax_d = ax_q + 1'b1;
                end
              end
            end
          end else if (better) begin
            st_d    = ST_PRE;
            sel_d   = cand_idx;
            lk_d    = '0;
            to_d    = '0;
            ax_d    = '0;
            restart = 1'b1;
          end else if (sec_tick) begin
            if (phase_lock && (lk_q == LCW'(LOCK_SECS - 1))) begin
              st_d = ST_LOCK;
              lk_d = '0;
              to_d = '0;
            end else if (to_hit) begin
              expire = 1'b1;
              st_d   = ST_PRE;
              lk_d   = '0;
              to_d   = '0;
              ax_d   = '0;
              if (cand_any) begin
                sel_d   = cand_idx;
                restart = 1'b1;
              end else begin
                selv_d = 1'b0;
              end
            end else begin
              lk_d = phase_lock ? lk_q + 1'b1 : '0;
              if (to_q != '1) to_d = to_q + 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (!sel_ok) begin
            st_d   = ST_HOLD;
            selv_d = 1'b0;
          end else if (!phase_lock) begin
            st_d = ST_LOL;
            ax_d = '0;
          end else if (better) begin
            st_d    = ST_PRE;
            sel_d   = cand_idx;
            lk_d    = '0;
            to_d    = '0;
            restart = 1'b1;
          end
        end
        ST_LOL: begin
          if (!sel_ok) begin
            st_d   = ST_HOLD;
            selv_d = 1'b0;
          end else if (phase_lock) begin
            st_d = ST_LOCK;
          end else if (sec_tick) begin
            if (ax_q == ACW'(LOL_SECS - 1)) begin
              st_d = ST_PRE2;
              ax_d = '0;
              lk_d = '0;
              to_d = '0;
            end else begin
              ax_d = ax_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (cand_any) begin
            st_d   = ST_PRE2;
            sel_d  = cand_idx;
            selv_d = 1'b1;
            lk_d   = '0;
            to_d   = '0;
            ax_d   = '0;
          end
        end
        default: begin
          st_d   = ST_FREE;
          selv_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FREE;
      sel_q  <= '0;
      selv_q <= 1'b0;
      lk_q   <= '0;
      to_q   <= '0;
      ax_q   <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      selv_q <= selv_d;
      lk_q   <= lk_d;
      to_q   <= to_d;
      ax_q   <= ax_d;
    end
  end

  assign chg_evt = (st_d != st_q) | restart;

  smc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(chg_evt), .clr(chg_clr), .en(irq_en),
    .sticky(chg_sticky), .irq(irq)
  );

  assign state_o   = st_q;
  assign sel_o     = sel_q;
  assign sel_vld_o = selv_q;
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk #(
  parameter int N_IN = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sec_tick,
  input logic            phase_lock,
  input logic            force_we,
  input logic            chg_clr,
  input logic [2:0]      state_o,
  input logic [N_IN-1:0] alarm_o,
  input logic            chg_sticky
);
  p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);

  p_alarm_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alarm_o));

  p_alarm_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|alarm_o) |-> $past(sec_tick));

  p_sticky_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != $past(state_o)) |-> chg_sticky);

  p_sticky_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_sticky && !chg_clr) |=> chg_sticky);

  p_lock_needs_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd2) && (($past(state_o) == 3'd3) || ($past(state_o) == 3'd4)))
      |-> (($past(phase_lock) && $past(sec_tick)) || $past(force_we)));

  p_free_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd0) && ($past(state_o) == 3'd3))
      |-> ($past(sec_tick) || $past(force_we)));
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk #(.N_IN(N_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .phase_lock(phase_lock),
  .force_we(force_we), .chg_clr(chg_clr), .state_o(state_o),
  .alarm_o(alarm_o), .chg_sticky(chg_sticky)
);

// File: tb/sync_mode_ctrl_tb_top.sv
module sync_mode_ctrl_tb_top;
  localparam int N  = 4;
  localparam int PW = 3;
  localparam int NV = 30;

  typedef struct packed {
    logic       fw;
    logic [2:0] fs;
    logic [3:0] vld;
    logic       pl;
    logic       tk;
    logic [2:0] es;
    logic       ev;
    logic [1:0] esel;
    logic [3:0] ealm;
  } vec_t;

  // prio: in0=2 in1=1 in2=3 in3=1 ; lock_timeout=3 ; revert off
  localparam vec_t VEC [NV] = '{
    '{1'b0,3'd0,4'b0000,1'b0,1'b0,3'd0,1'b0,2'd0,4'b0000}, // 1  R1 idle
    '{1'b0,3'd0,4'b0001,1'b0,1'b0,3'd3,1'b1,2'd0,4'b0000}, // 2  R2
    '{1'b0,3'd0,4'b0001,1'b1,1'b1,3'd3,1'b1,2'd0,4'b0000}, // 3  R3
    '{1'b0,3'd0,4'b0001,1'b1,1'b1,3'd2,1'b1,2'd0,4'b0000}, // 4  R3
    '{1'b0,3'd0,4'b0001,1'b0,1'b0,3'd5,1'b1,2'd0,4'b0000}, // 5  R7
    '{1'b0,3'd0,4'b0001,1'b1,1'b0,3'd2,1'b1,2'd0,4'b0000}, // 6  R7
    '{1'b0,3'd0,4'b0001,1'b0,1'b0,3'd5,1'b1,2'd0,4'b0000}, // 7  R7
    '{1'b0,3'd0,4'b0001,1'b0,1'b1,3'd5,1'b1,2'd0,4'b0000}, // 8  R7
    '{1'b0,3'd0,4'b0001,1'b0,1'b1,3'd4,1'b1,2'd0,4'b0000}, // 9  R7
    '{1'b0,3'd0,4'b0001,1'b0,1'b1,3'd4,1'b1,2'd0,4'b0000}, // 10 R4
    '{1'b0,3'd0,4'b0001,1'b0,1'b1,3'd4,1'b1,2'd0,4'b0000}, // 11 R4
    '{1'b0,3'd0,4'b0001,1'b0,1'b1,3'd3,1'b0,2'd0,4'b0001}, // 12 R4
    '{1'b0,3'd0,4'b0001,1'b0,1'b0,3'd3,1'b0,2'd0,4'b0000}, // 13 R5
    '{1'b0,3'd0,4'b0001,1'b0,1'b1,3'd3,1'b0,2'd0,4'b0000}, // 14 R5
    '{1'b0,3'd0,4'b0001,1'b0,1'b1,3'd0,1'b0,2'd0,4'b0000}, // 15 R5
    '{1'b0,3'd0,4'b0000,1'b0,1'b0,3'd0,1'b0,2'd0,4'b0000}, // 16 R2
    '{1'b0,3'd0,4'b0101,1'b0,1'b0,3'd3,1'b1,2'd0,4'b0000}, // 17 R2
    '{1'b0,3'd0,4'b0111,1'b0,1'b0,3'd3,1'b1,2'd0,4'b0000}, // 18 R6
    '{1'b0,3'd0,4'b0111,1'b1,1'b1,3'd3,1'b1,2'd0,4'b0000}, // 19 R3
    '{1'b0,3'd0,4'b0111,1'b1,1'b1,3'd2,1'b1,2'd0,4'b0000}, // 20 R3
    '{1'b0,3'd0,4'b0110,1'b1,1'b0,3'd1,1'b0,2'd0,4'b0000}, // 21 R8
    '{1'b0,3'd0,4'b0110,1'b0,1'b0,3'd4,1'b1,2'd1,4'b0000}, // 22 R8
    '{1'b0,3'd0,4'b0110,1'b0,1'b1,3'd4,1'b1,2'd1,4'b0000}, // 23 R4
    '{1'b0,3'd0,4'b0110,1'b0,1'b1,3'd4,1'b1,2'd1,4'b0000}, // 24 R4
    '{1'b0,3'd0,4'b0110,1'b0,1'b1,3'd3,1'b1,2'd2,4'b0010}, // 25 R4
    '{1'b0,3'd0,4'b0110,1'b0,1'b0,3'd3,1'b1,2'd2,4'b0000}, // 26 R4
    '{1'b1,3'd1,4'b0000,1'b0,1'b0,3'd1,1'b0,2'd0,4'b0000}, // 27 R9
    '{1'b1,3'd6,4'b0000,1'b0,1'b0,3'd1,1'b0,2'd0,4'b0000}, // 28 R9
    '{1'b1,3'd0,4'b0000,1'b0,1'b0,3'd0,1'b0,2'd0,4'b0000}, // 29 R9
    '{1'b0,3'd0,4'b0000,1'b0,1'b0,3'd0,1'b0,2'd0,4'b0000}  // 30 R9
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sec_tick = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*PW-1:0] prio_i = {3'd1, 3'd3, 3'd1, 3'd2};
  logic            phase_lock = 1'b0;
  logic            revert_en = 1'b0;
  logic [7:0]      lock_timeout = 8'd3;
  logic            force_we = 1'b0;
  logic [2:0]      force_code = 3'd0;
  logic            chg_clr = 1'b0;
  logic            irq_en = 1'b0;
  logic [2:0]      state_o;
  logic [1:0]      sel_o;
  logic            sel_vld_o;
  logic [N-1:0]    alarm_o;
  logic            chg_sticky;
  logic            irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .in_valid(in_valid),
    .prio_i(prio_i), .phase_lock(phase_lock), .revert_en(revert_en),
    .lock_timeout(lock_timeout), .force_we(force_we), .force_code(force_code),
    .chg_clr(chg_clr), .irq_en(irq_en), .state_o(state_o), .sel_o(sel_o),
    .sel_vld_o(sel_vld_o), .alarm_o(alarm_o), .chg_sticky(chg_sticky), .irq(irq)
  );

  function automatic string row_req(int r);
    if (r == 0) return "R1";
    if (r == 1 || r == 15 || r == 16) return "R2";
    if (r <= 3 || r == 18 || r == 19) return "R3";
    if (r <= 8) return "R7";
    if (r <= 11 || (r >= 22 && r <= 25)) return "R4";
    if (r <= 14) return "R5";
    if (r == 17) return "R6";
    if (r <= 21) return "R8";
    return "R9";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // inputs were set at a falling edge; one rising edge passes; sample at next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulses_off();
    sec_tick = 1'b0;
    force_we = 1'b0;
    chg_clr  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {29'd0, state_o}, 32'd0, "state");
    chk("R1", {31'd0, sel_vld_o}, 32'd0, "sel_vld");
    chk("R1", {28'd0, alarm_o}, 32'd0, "alarm");
    chk("R1", {30'd0, chg_sticky, irq}, 32'd0, "sticky/irq");
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < NV; r++) begin
      force_we   = VEC[r].fw;
      force_code = VEC[r].fs;
      in_valid   = VEC[r].vld;
      phase_lock = VEC[r].pl;
      sec_tick   = VEC[r].tk;
      step();
      chk(row_req(r), {29'd0, state_o}, {29'd0, VEC[r].es}, $sformatf("row %0d state", r + 1));
      chk(row_req(r), {31'd0, sel_vld_o}, {31'd0, VEC[r].ev}, $sformatf("row %0d sel_vld", r + 1));
      if (VEC[r].ev)
        chk(row_req(r), {30'd0, sel_o}, {30'd0, VEC[r].esel}, $sformatf("row %0d sel", r + 1));
      chk(row_req(r), {28'd0, alarm_o}, {28'd0, VEC[r].ealm}, $sformatf("row %0d alarm", r + 1));
      pulses_off();
    end

    // R10: sticky status, enable gate and clear
    chk("R10", {31'd0, chg_sticky}, 32'd1, "sticky after changes");
    chk("R10", {31'd0, irq}, 32'd0, "irq while disabled");
    irq_en = 1'b1;
    #1;
    chk("R10", {31'd0, irq}, 32'd1, "irq once enabled");
    chg_clr = 1'b1;
    step();
    pulses_off();
    chk("R10", {30'd0, chg_sticky, irq}, 32'd0, "sticky/irq after clear");

    // R6: revertive restart on a better input (now in free-run, no inputs)
    revert_en = 1'b1;
    in_valid  = 4'b0001;
    step();
    chk("R6", {29'd0, state_o}, 32'd3, "enter prelocked");
    chk("R6", {30'd0, sel_o}, 32'd0, "first select");
    chg_clr = 1'b1;
    step();
    pulses_off();
    chk("R10", {31'd0, chg_sticky}, 32'd0, "cleared with no event");
    in_valid = 4'b0011;
    step();
    chk("R6", {29'd0, state_o}, 32'd3, "restart state");
    chk("R6", {30'd0, sel_o}, 32'd1, "revert to input 1");
    chk("R10", {31'd0, chg_sticky}, 32'd1, "restart sets sticky");

    // R4: timeout value 0 never expires
    lock_timeout = 8'd0;
    for (int k = 0; k < 5; k++) begin
      sec_tick = 1'b1;
      step();
      pulses_off();
      chk("R4", {28'd0, alarm_o}, 32'd0, "no alarm with timeout 0");
      chk("R4", {29'd0, state_o}, 32'd3, "still prelocked with timeout 0");
    end
    chk("R4", {30'd0, sel_o}, 32'd1, "selection kept with timeout 0");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule